// File: doc/BRIEF.md
# Serial PHY Management Register Engine

This block turns one 32-bit control word, written by a host, into a complete clause-22 management frame on a two-wire serial link toward an Ethernet PHY. The host places the opcode, PHY address, register address and write data in the control word. Writing the word starts the frame. The block produces the management clock and drives the data line, with a separate output enable so that the line can be released while the PHY answers. It then reports completion through a ready flag in the same word.

For a read, the sixteen bits that the PHY returns replace the low half of the word before the ready flag rises. Completion also raises a one-cycle done pulse, which the surrounding logic uses as an interrupt cause. A read of the PHY identifier register (address 3) also updates a presence flag, so that firmware can tell whether a PHY answers at that address.

Top module: `mgmt_reg_engine`

## Requirements
- R1: After reset the control word reads 0x1000_0000, which means ready is set and every other field is 0. After reset the management clock, data output, output enable, done pulse and presence flag are all 0.
- R2: A write accepted while ready is set stores bits 27:0 of the written value. From the next cycle, ready (bit 28) reads 0 and bits 31:29 read 0.
- R3: Each frame is 64 bits long and is sent MSB first in this order:
  - 32 ones;
  - the pair 0,1;
  - the opcode (bits 27:26);
  - the PHY address (bits 25:21);
  - the register address (bits 20:16).
- R4: When the opcode is 10 (read), the output enable is 0 for frame bits 46 to 63. The bits sampled on the last 16 rising clock edges, MSB first, replace bits 15:0 of the word.
- R5: The data output changes only on falling edges of the management clock and never in the cycle in which the clock rises. Input data is sampled on rising edges.
- R6: The management clock stays 0 while the block is idle. During a frame its half period is max(1, mdc_half) system clock cycles, and its first rising edge comes one half period after the write.
- R7: When a frame finishes, ready is set and mgmt_done is high for exactly one cycle, in the same cycle that ready rises. At the same point the management clock returns to 0 and the output enable drops.
- R8: A write that arrives while a frame is in progress has no effect. The stored word stays unchanged and the frame in progress completes with its original content.
- R9: When a read of register address 3 completes, phy_present becomes 1 if bits 9:4 of the returned data are nonzero and 0 otherwise. Any other transaction leaves phy_present unchanged.
- R10: Any opcode other than 10 is sent as a write. The line is driven for all 64 bits, with turnaround 1,0 and then bits 15:0 of the word, and the low half of the word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word: ready in bit 28, fields in bits 27:0 |
| mdc_half | input | DIV_W | Half period of the management clock in system cycles (0 is treated as 1) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the line |
| mgmt_done | output | 1 | One-cycle pulse when a frame completes |
| phy_present | output | 1 | Result of the last identifier-register read |

## Verification
The assertions assume that mdc_half is held steady while a frame is running. They also assume that the host issues no reset in the middle of a frame. The stimulus changes the divider setting only between transactions, while ready is set. The PHY model in the bench changes mdio_i only on falling edges of the management clock, so each sampled bit is stable at the rising edge. Writes during a frame are injected on purpose, well inside the frame, to exercise the ignore rule.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int OP_W       = 2;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int REG_W      = 32;
  localparam int PRE_BITS   = 32;
  localparam int CMD_W      = OP_W + 2 * ADDR_W + DATA_W;
  localparam int READY_BIT  = CMD_W;
  localparam int TA_FIRST   = PRE_BITS + 2 + OP_W + 2 * ADDR_W;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int FRAME_BITS = DATA_FIRST + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int ID_LO      = 4;
  localparam int ID_HI      = 9;

  localparam logic [OP_W-1:0]   OP_READ = 2'b10;
  localparam logic [ADDR_W-1:0] ID_REG  = 5'd3;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_en,
  output logic             fall_en
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;
  logic             mdc_q, mdc_d, term;

  always_comb begin
    limit   = (half == '0) ? DIV_W'(1) : half;
    term    = run && (cnt_q == limit - 1'b1);
    rise_en = term && !mdc_q;
    fall_en = term && mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mgmt_frame_shifter.sv
module mgmt_frame_shifter
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              mdio_i,
  output logic              busy,
  output logic              finish,
  output logic              is_read,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  busy_q, busy_d, rd_q, rd_d, last, in_data, released;

  always_comb begin
    last     = (idx_q == IDX_W'(FRAME_BITS - 1));
    in_data  = (idx_q >= IDX_W'(DATA_FIRST));
    released = rd_q && (idx_q >= IDX_W'(TA_FIRST));
    finish   = busy_q && fall_en && last;
    busy_d   = busy_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    rd_d     = rd_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      rd_d   = (cmd.op == OP_READ);
      rx_d   = '0;
      if (cmd.op == OP_READ)
        sh_d = {{PRE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad, {(DATA_W + 2){1'b0}}};
      else
        sh_d = {{PRE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad, 2'b10, cmd.data};
    end else if (busy_q) begin
      if (rise_en && rd_q && in_data)
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_en) begin
        if (last) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rx_q   <= rx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
    end
  end

  assign busy    = busy_q;
  assign is_read = rd_q;
  assign rx_data = rx_q;
  assign mdio_o  = busy_q && sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !released;
endmodule

// File: rtl/mgmt_reg_engine.sv
module mgmt_reg_engine
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [DIV_W-1:0] mdc_half,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic             mgmt_done,
  output logic             phy_present
);
  cmd_t              cmd_q, cmd_d, cmd_in;
  logic              ready_q, ready_d, pres_q, pres_d, done_q, done_d;
  logic              busy, finish, is_read, start, rise_en, fall_en;
  logic [DATA_W-1:0] rx_data;

  assign cmd_in = cmd_t'(wr_data[CMD_W-1:0]);
  assign start  = wr_en && !busy;

  mgmt_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .half    (mdc_half),
    .mdc     (mdc),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  mgmt_frame_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd     (cmd_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .finish  (finish),
    .is_read (is_read),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rx_data (rx_data)
  );

  always_comb begin
    cmd_d   = cmd_q;
    ready_d = ready_q;
    pres_d  = pres_q;
    done_d  = finish;
    if (start) begin
      cmd_d   = cmd_in;
      ready_d = 1'b0;
    end else if (finish) begin
      ready_d = 1'b1;
      if (is_read) begin
        cmd_d.data = rx_data;
        if (cmd_q.regad == ID_REG)
          pres_d = |rx_data[ID_HI:ID_LO];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b1;
      pres_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      ready_q <= ready_d;
      pres_q  <= pres_d;
      done_q  <= done_d;
    end
  end

  assign rd_data     = {{(REG_W - CMD_W - 1){1'b0}}, ready_q, cmd_q};
  assign mgmt_done   = done_q;
  assign phy_present = pres_q;
endmodule

// File: rtl/mgmt_reg_engine_chk.sv
module mgmt_reg_engine_chk
  import mgmt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        busy,
  input logic [31:0] rd_data,
  input logic        mgmt_done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r2_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_data[READY_BIT] |=> !rd_data[READY_BIT]);

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_data[READY_BIT] |=> $stable(rd_data[CMD_W-1:DATA_W]));

  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_done |-> rd_data[READY_BIT]);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_done |=> !mgmt_done);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[READY_BIT] |-> (!mdc && !mdio_oe && !mdio_o));

  a_r5_no_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));

  a_r2_ready_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[READY_BIT] == !busy);
endmodule

bind mgmt_reg_engine mgmt_reg_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .busy      (busy),
  .rd_data   (rd_data),
  .mgmt_done (mgmt_done),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mgmt_reg_engine_test.sv
module mgmt_reg_engine_test;
  localparam int DIV_W = 8;

  logic             clk, rst_n, wr_en, mdio_i;
  logic [31:0]      wr_data, rd_data;
  logic [DIV_W-1:0] mdc_half;
  logic             mdc, mdio_o, mdio_oe, mgmt_done, phy_present;

  int          n_chk = 0, n_fail = 0, rise_cnt = 0;
  logic        finished = 1'b0;
  logic [63:0] got_o, got_oe;
  logic [15:0] phy_rd;
  realtime     t0, t1;
  logic        exp_pres = 1'b0;

  mgmt_reg_engine #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mdc_half(mdc_half), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .mgmt_done(mgmt_done), .phy_present(phy_present)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // PHY model: records the frame on rising edges, answers on falling edges
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      got_o[63-rise_cnt]  = mdio_o;
      got_oe[63-rise_cnt] = mdio_oe;
    end
    if (rise_cnt == 0) t0 = $realtime;
    if (rise_cnt == 1) t1 = $realtime;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i <= phy_rd[63-rise_cnt];
    else mdio_i <= 1'b1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                     input logic [15:0] data, input int half, input logic [15:0] rdv,
                     input logic [2:0] top, input logic inject);
    logic [31:0] w, exp_w;
    logic [63:0] ef, eoe;
    int hp, waitc;
    logic rd;
    rd = (op == 2'b10);
    hp = (half == 0) ? 1 : half;
    w = {top, 1'b1, op, phy, ra, data};
    ef = rd ? {32'hFFFF_FFFF, 2'b01, op, phy, ra, 18'd0}
            : {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, data};
    for (int i = 0; i < 64; i++) eoe[63-i] = !(rd && i >= 46);
    mdc_half = DIV_W'(half);
    phy_rd = rdv;
    rise_cnt = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    exp_w = {3'b000, 1'b0, w[27:0]};
    chk(rd_data == exp_w, "R2 stored word", 64'(rd_data), 64'(exp_w));
    if (inject) begin
      repeat (40) @(negedge clk);
      wr_en = 1'b1; wr_data = ~w;
      @(negedge clk);
      wr_en = 1'b0;
      chk(rd_data == exp_w, "R8 busy write ignored", 64'(rd_data), 64'(exp_w));
    end
    waitc = 0;
    while (!mgmt_done && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    exp_w = {3'b000, 1'b1, w[27:16], rd ? rdv : data};
    chk(mgmt_done == 1'b1, "R7 done seen", 64'(mgmt_done), 64'd1);
    chk(rd_data == exp_w, rd ? "R4 read result" : "R10 write keeps data",
        64'(rd_data), 64'(exp_w));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R7 line idle at end", {62'd0, mdc, mdio_oe}, 64'd0);
    chk(rise_cnt == 64, "R3 frame length", 64'(rise_cnt), 64'd64);
    chk(got_oe == eoe, rd ? "R4 release pattern" : "R10 drive pattern", got_oe, eoe);
    chk((got_o & eoe) == (ef & eoe), "R3 frame bits", got_o & eoe, ef & eoe);
    chk((t1 - t0) == realtime'(20 * hp), "R6 clock period",
        64'($rtoi(t1 - t0)), 64'(20 * hp));
    if (rd && ra == 5'd3) exp_pres = |rdv[9:4];
    chk(phy_present == exp_pres, "R9 presence flag", 64'(phy_present), 64'(exp_pres));
    @(negedge clk);
    chk(mgmt_done == 1'b0, "R7 single pulse", 64'(mgmt_done), 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mdc_half = '0; mdio_i = 1'b1; phy_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'h1000_0000, "R1 reset word", 64'(rd_data), 64'h1000_0000);
    chk({mdc, mdio_o, mdio_oe, mgmt_done, phy_present} == 5'd0, "R1 reset outputs",
        64'({mdc, mdio_o, mdio_oe, mgmt_done, phy_present}), 64'd0);
    repeat (5) @(negedge clk);
    chk(mdc == 1'b0, "R6 idle clock", 64'(mdc), 64'd0);
    // sweep opcodes and divider settings
    for (int op = 0; op < 4; op++)
      for (int h = 0; h < 4; h++)
        txn(2'(op), 5'(op * 7 + h), 5'(h * 9 + 1), 16'hA5C3 ^ 16'(op * 4 + h),
            h, 16'h3C5A ^ 16'(h * 257), 3'(op + h), 1'b0);
    // identifier register reads: nonzero, zero and single-bit field values
    txn(2'b10, 5'd1, 5'd3, 16'h0000, 1, 16'h0010, 3'b111, 1'b0);
    txn(2'b10, 5'd1, 5'd3, 16'h0000, 1, 16'hFC0F, 3'b000, 1'b0);
    txn(2'b01, 5'd1, 5'd3, 16'hFFFF, 1, 16'h0000, 3'b000, 1'b0);
    txn(2'b10, 5'd2, 5'd3, 16'h0000, 2, 16'h0200, 3'b000, 1'b0);
    txn(2'b10, 5'd2, 5'd4, 16'h0000, 1, 16'h0000, 3'b000, 1'b0);
    // writes during a running frame
    txn(2'b01, 5'd31, 5'd31, 16'h8001, 2, 16'h0000, 3'b000, 1'b1);
    txn(2'b10, 5'd16, 5'd0, 16'h0000, 3, 16'hFFFF, 3'b000, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule